// File: doc/BRIEF.md
# Peripheral Module Standby Controller

This block decides which on-chip peripherals of a small microcontroller subsystem are running and which are parked. Software writes a stop register with one bit per peripheral over a plain CPU register bus. The block does not apply a change at once. It holds the change pending and moves each peripheral's run enable and synchronous reset only on a clock edge where the bus-cycle-end strobe is high. A stopped peripheral is held in reset, so its state returns to its initial values. The CPU's accesses to that peripheral's register window are cut off: a read returns zero and a write never reaches the peripheral. Bus timing does not change.

The CPU itself keeps running, and it can always reach the control registers. A second control register holds the port high-impedance bit. During software standby this bit chooses whether the I/O ports keep their levels or float.

Address map (8-bit address): the upper nibble selects a window and the lower nibble is the offset inside it. Windows 0 to 7 belong to modules 0 to 7. Window 8 holds the controls: offset 0 is the stop register and offset 1 is the port control register.

Top module: `pstby_ctrl`

## Requirements
- R1: After reset, the stop register reads 16'h001F. Modules 0 to 4 (serial interface, multifunction timer, motor timer, compare-match timer, ADC) are stopped, modules 5 to 7 run, and the high-impedance bit is 0.
- R2: The stop register at address 8'h80 holds module i's stop bit in bit i, with 1 meaning stopped. Bits 15:8 read 0 and ignore writes. Control accesses work whatever the stop bits hold.
- R3: `mod_run` changes only on a clock edge where `cyc_end` is 1. At that edge it becomes the inverse of the stop register value, including a write made in that same cycle. A write made without the strobe stays pending.
- R4: `mod_rst[i]` is 1 for exactly as long as module i is stopped, that is, whenever `mod_run[i]` is 0.
- R5: Rewriting a stop bit with the value it already holds changes neither `mod_run` nor `mod_rst` on any cycle.
- R6: A read of a stopped module's window returns 16'h0000 and leaves that module's `periph_sel` bit at 0.
- R7: A write to a stopped module's window leaves that module's `periph_sel` bit at 0, so the write is dropped. The bus still takes a single cycle.
- R8: An access to a running module's window raises only that module's `periph_sel` bit. It passes the low address nibble on `periph_addr`. A read returns that module's `periph_rdata` slice.
- R9: The port control register at 8'h81 holds the high-impedance bit in bit 0. While `sw_standby` is 1, `port_hold` equals the inverse of that bit and `port_hiz` equals the bit. While `sw_standby` is 0, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_req | input | 1 | Bus access in this cycle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 8 | Window (upper nibble) and offset |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Read data |
| cyc_end | input | 1 | Bus-cycle-end strobe |
| sw_standby | input | 1 | Software standby active |
| mod_run | output | 8 | Per-module run enable |
| mod_rst | output | 8 | Per-module synchronous reset |
| periph_sel | output | 8 | Per-module register select |
| periph_we | output | 1 | Write strobe to peripherals |
| periph_addr | output | 4 | Offset inside the window |
| periph_wdata | output | 16 | Write data to peripherals |
| periph_rdata | input | 128 | Read data, module i in bits 16i+15:16i |
| port_hold | output | 1 | Hold I/O port states |
| port_hiz | output | 1 | Float I/O ports |

## Verification
The bench writes every one of the 256 stop patterns. Each write carries junk in the upper byte and comes without the strobe, which separates "stored and readable" from "applied". A strobe-only cycle then follows and must apply the pattern. For every pattern, every module window is read and written, which separates running from stopped windows for each bit position and shows any leak into a neighbour's select. A write made in the strobe cycle itself, identical rewrites watched cycle by cycle, and all four combinations of standby and high-impedance bit cover the edge timing, glitch freedom and port control.

// File: rtl/pstby_ctrl.sv
module pstby_ctrl #(
  parameter int NUM_MODS = 8,
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 8,
  parameter int OFS_W    = 4,
  parameter logic [NUM_MODS-1:0] RST_STOP = 8'h1F
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cpu_req,
  input  logic                       cpu_we,
  input  logic [ADDR_W-1:0]          cpu_addr,
  input  logic [DATA_W-1:0]          cpu_wdata,
  output logic [DATA_W-1:0]          cpu_rdata,
  input  logic                       cyc_end,
  input  logic                       sw_standby,
  output logic [NUM_MODS-1:0]        mod_run,
  output logic [NUM_MODS-1:0]        mod_rst,
  output logic [NUM_MODS-1:0]        periph_sel,
  output logic                       periph_we,
  output logic [OFS_W-1:0]           periph_addr,
  output logic [DATA_W-1:0]          periph_wdata,
  input  logic [NUM_MODS*DATA_W-1:0] periph_rdata,
  output logic                       port_hold,
  output logic                       port_hiz
);
  localparam int WIN_W    = ADDR_W - OFS_W;
  localparam int CTRL_WIN = NUM_MODS;

  logic [WIN_W-1:0]    win;
  logic [OFS_W-1:0]    ofs;
  logic                ctrl_hit, stop_wr, hiz_wr;
  logic [NUM_MODS-1:0] stop_q, stop_d, run_q, mod_hit;
  logic                hiz_q;

  assign win      = cpu_addr[ADDR_W-1:OFS_W];
  assign ofs      = cpu_addr[OFS_W-1:0];
  assign ctrl_hit = cpu_req && (win == WIN_W'(CTRL_WIN));
  assign stop_wr  = ctrl_hit && cpu_we && (ofs == OFS_W'(0));
  assign hiz_wr   = ctrl_hit && cpu_we && (ofs == OFS_W'(1));
  assign stop_d   = stop_wr ? cpu_wdata[NUM_MODS-1:0] : stop_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stop_q <= RST_STOP;
      run_q  <= ~RST_STOP;
      hiz_q  <= 1'b0;
    end else begin
      stop_q <= stop_d;
      if (cyc_end) run_q <= ~stop_d;
      if (hiz_wr)  hiz_q <= cpu_wdata[0];
    end
  end

  assign mod_run      = run_q;
  assign mod_rst      = ~run_q;
  assign periph_we    = cpu_we;
  assign periph_addr  = ofs;
  assign periph_wdata = cpu_wdata;
  assign port_hold    = sw_standby & ~hiz_q;
  assign port_hiz     = sw_standby & hiz_q;

  for (genvar i = 0; i < NUM_MODS; i++) begin : g_mod
    assign mod_hit[i]    = cpu_req && (win == WIN_W'(i));
    assign periph_sel[i] = mod_hit[i] && run_q[i];

    // R6
    blocked_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (mod_hit[i] && !cpu_we && !mod_run[i]) |-> (cpu_rdata == '0));
  end

  always_comb begin
    cpu_rdata = '0;
    if (ctrl_hit && !cpu_we) begin
      if (ofs == OFS_W'(0)) cpu_rdata[NUM_MODS-1:0] = stop_q;
      else if (ofs == OFS_W'(1)) cpu_rdata[0] = hiz_q;
    end
    for (int i = 0; i < NUM_MODS; i++)
      if (periph_sel[i] && !cpu_we) cpu_rdata = periph_rdata[i*DATA_W +: DATA_W];
  end

  // R3
  run_moves_on_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (mod_run != $past(mod_run)) |-> $past(cyc_end));

  // R3
  run_follows_stop_chk: assert property (@(posedge clk) disable iff (rst)
    $past(cyc_end) |-> (mod_run == ~stop_q));

  // R2
  stop_held_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(stop_wr) |-> $stable(stop_q));

  // R9
  port_mode_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({port_hold, port_hiz}));

  // R8
  single_select_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(periph_sel));
endmodule

// File: tb/pstby_ctrl_tb.sv
module pstby_ctrl_tb_top;
  localparam int N = 8;

  logic clk = 0, rst = 1;
  logic cpu_req = 0, cpu_we = 0, cyc_end = 0, sw_standby = 0;
  logic [7:0] cpu_addr = '0;
  logic [15:0] cpu_wdata = '0, cpu_rdata, periph_wdata;
  logic [N-1:0] mod_run, mod_rst, periph_sel;
  logic periph_we, port_hold, port_hiz;
  logic [3:0] periph_addr;
  logic [N*16-1:0] periph_rdata;
  int n_chk = 0, n_fail = 0;
  logic [15:0] cap_rdata;
  logic [N-1:0] cap_sel;
  logic [3:0] cap_addr;

  always #2 clk = ~clk;

  for (genvar i = 0; i < N; i++) begin : g_pd
    assign periph_rdata[i*16 +: 16] = 16'hC000 + 16'(i) * 16'h0101;
  end

  pstby_ctrl dut_i (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cyc_end(cyc_end),
    .sw_standby(sw_standby), .mod_run(mod_run), .mod_rst(mod_rst),
    .periph_sel(periph_sel), .periph_we(periph_we), .periph_addr(periph_addr),
    .periph_wdata(periph_wdata), .periph_rdata(periph_rdata),
    .port_hold(port_hold), .port_hiz(port_hiz));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input bit req, input bit we, input logic [7:0] a, input logic [15:0] d, input bit strb);
    @(negedge clk);
    cpu_req = req; cpu_we = we; cpu_addr = a; cpu_wdata = d; cyc_end = strb;
    #1;
    cap_rdata = cpu_rdata; cap_sel = periph_sel; cap_addr = periph_addr;
    @(posedge clk); #1;
    cpu_req = 0; cpu_we = 0; cyc_end = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [N-1:0] prev, rst_seen;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    // R1 reset state
    cyc(1, 0, 8'h80, 0, 0);
    check(cap_rdata == 16'h001F, "R1 stop reset", cap_rdata, 16'h001F);
    check(mod_run == 8'hE0, "R1 run reset", mod_run, 8'hE0);
    check(mod_rst == 8'h1F, "R1 rst reset", mod_rst, 8'h1F);
    cyc(1, 0, 8'h81, 0, 0);
    check(cap_rdata == 16'h0000, "R1 hiz reset", cap_rdata, 0);
    check(port_hold == 0 && port_hiz == 0, "R1 ports", {port_hold, port_hiz}, 0);

    prev = 8'hE0;
    for (int p = 0; p < 256; p++) begin
      cyc(1, 1, 8'h80, {8'h5A, 8'(p)}, 0);
      check(mod_run == prev, "R3 pending", mod_run, prev);
      cyc(1, 0, 8'h80, 0, 0);
      check(cap_rdata == 16'(p), "R2 readback", cap_rdata, 16'(p));
      cyc(0, 0, 0, 0, 1);
      check(mod_run == ~8'(p), "R3 applied", mod_run, ~8'(p));
      check(mod_rst == 8'(p), "R4 rst level", mod_rst, 8'(p));
      prev = ~8'(p);
      for (int m = 0; m < N; m++) begin
        logic [15:0] exp_d;
        logic [N-1:0] exp_s;
        exp_s = p[m] ? '0 : (N'(1) << m);
        exp_d = p[m] ? 16'h0 : 16'hC000 + 16'(m) * 16'h0101;
        cyc(1, 0, {4'(m), 4'h3}, 0, 0);
        check(cap_sel == exp_s, p[m] ? "R6 read sel" : "R8 read sel", cap_sel, exp_s);
        check(cap_rdata == exp_d, p[m] ? "R6 read data" : "R8 read data", cap_rdata, exp_d);
        check(cap_addr == 4'h3, "R8 offset", cap_addr, 3);
        cyc(1, 1, {4'(m), 4'h7}, 16'hBEEF, 0);
        check(cap_sel == exp_s, p[m] ? "R7 write sel" : "R8 write sel", cap_sel, exp_s);
      end
    end

    // R3 write in the strobe cycle applies at once
    cyc(1, 1, 8'h80, 16'h0033, 1);
    check(mod_run == 8'hCC, "R3 same-cycle", mod_run, 8'hCC);

    // R5 identical rewrites, watched for several cycles
    rst_seen = '0;
    for (int k = 0; k < 6; k++) begin
      cyc(1, 1, 8'h80, 16'h0033, k[0]);
      rst_seen = rst_seen | (mod_rst ^ 8'h33);
    end
    check(rst_seen == 0, "R5 no glitch", rst_seen, 0);
    check(mod_run == 8'hCC, "R5 run kept", mod_run, 8'hCC);

    // R9 sweep
    for (int h = 0; h < 2; h++) begin
      cyc(1, 1, 8'h81, 16'hFFFE | 16'(h), 0);
      cyc(1, 0, 8'h81, 0, 0);
      check(cap_rdata == 16'(h), "R9 hiz readback", cap_rdata, h);
      for (int s = 0; s < 2; s++) begin
        @(negedge clk) sw_standby = s[0];
        #1;
        check(port_hold == (s[0] & ~h[0]), "R9 hold", port_hold, s[0] & ~h[0]);
        check(port_hiz == (s[0] & h[0]), "R9 hiz", port_hiz, s[0] & h[0]);
      end
      sw_standby = 0;
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule